// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Register

This block is the interrupt register for a single processor. It keeps a 32-bit pending word and exposes it through a small register interface. The interface is word addressed and takes full 32-bit accesses only. Software uses two write offsets to raise or drop soft-interrupt requests. These requests live in the upper half of the word and map onto processor levels 1 to 15. The word is also fed from two hardware sources. One is a per-processor timer line, which lands in bit 14. The other is a broadcast level-15 line, which lands in bit 15.

Each clock the block combines several inputs into a registered 16-bit vector of active processor interrupt levels. The inputs are the pending word, a hard-interrupt level vector from the system controller, a flag saying whether this processor is the current target, and a global master-off flag. Software can clear bit 15 but cannot set it. Bits 14 and 15 are held back only by the master-off flag, not by any per-source mask.

Top module: `cpi_irq_pend`

## Requirements
- R1: A read (rd_en high) at word offset 0 returns the visible word on rdata one clock later. The visible word is the pending state before any write in the same cycle, ORed with hard_lvl bits 15..1 whenever is_target is high. A read at any other offset returns zero, and rdata is zero in every cycle that follows no read.
- R2: A write to offset 1 clears the pending bits that are set in the written value. The value is first masked to bits 31..17 and bit 15.
- R3: A write to offset 2 sets the pending bits that are set in the written value. The value is first masked to bits 31..17, so bits 16..0 are never set this way. Writes to offsets 0 and 3 change nothing.
- R4: Pending bit 14 takes the level of timer_in sampled at each clock. Software clears do not affect it.
- R5: Pending bit 15 is set on a rising edge of l15_in and cleared on a falling edge. A software clear of bit 15 also clears it. When a rising edge and a software clear of bit 15 fall in the same cycle, the edge wins and the bit stays set.
- R6: Soft bit k (k = 17..31) drives output level k-16.
- R7: Pending bits 14 and 15 drive output levels 14 and 15 only while master_off is low.
- R8: While is_target is high and master_off is low, hard_lvl is ORed into the output vector.
- R9: Output bit 0 is always zero. In the visible word, bits 16 and 0 are always zero.
- R10: A synchronous reset (rst high) clears the pending word, the edge history of l15_in, the output vector and rdata.
- R11: The output vector is registered. It reflects the inputs and the write present at one clock edge right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (2) | Word offset of the access |
| wdata | input | PEND_W (32) | Write data |
| rdata | output | PEND_W (32) | Registered read data |
| timer_in | input | 1 | Per-processor timer request level |
| l15_in | input | 1 | Broadcast level-15 request level |
| hard_lvl | input | LVL_W (16) | Hard-interrupt level vector from the system controller |
| is_target | input | 1 | This processor is the hard-interrupt target |
| master_off | input | 1 | Global master-off flag |
| irl | output | LVL_W (16) | Registered vector of active interrupt levels |

## Verification
Two events can land on bit 15 in the same cycle: a software clear of that bit and a rising edge on the broadcast level-15 line. A directed step drives both on one edge and expects the bit to stay set. A following clear without an edge must then drop it. A read and a write in the same cycle also collide. The random phase issues them together freely, and a bench model compares rdata with the pre-write word and irl with the post-write word.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  // Word offsets decoded by the register interface (behaviour depends on them)
  localparam int unsigned OFS_VIEW = 0;
  localparam int unsigned OFS_CLR  = 1;
  localparam int unsigned OFS_SET  = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2
  } wr_op_e;
endpackage

// File: rtl/cpi_regif.sv
module cpi_regif #(
  parameter int ADDR_W = 2,
  parameter int PEND_W = 32,
  parameter int LVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PEND_W-1:0] wdata,
  input  logic [PEND_W-1:0] view,
  output logic [PEND_W-1:0] set_mask,
  output logic [PEND_W-1:0] clr_mask,
  output logic [PEND_W-1:0] rdata
);
  import cpi_pkg::*;

  localparam int SOFT_LO = LVL_W + 1;
  localparam int L15_BIT = LVL_W - 1;

  logic [PEND_W-1:0] soft_msk;
  wr_op_e            op;

  for (genvar i = 0; i < PEND_W; i++) begin : g_msk
    assign soft_msk[i] = (i >= SOFT_LO);
  end

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (addr == ADDR_W'(OFS_CLR))      op = OP_CLR;
      else if (addr == ADDR_W'(OFS_SET)) op = OP_SET;
    end
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    unique case (op)
      OP_SET:  set_mask = wdata & soft_msk;
      OP_CLR: begin
        clr_mask          = wdata & soft_msk;
        clr_mask[L15_BIT] = wdata[L15_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                      rdata <= '0;
    else if (rd_en && addr == ADDR_W'(OFS_VIEW))  rdata <= view;
    else                                          rdata <= '0;
  end
endmodule

// File: rtl/cpi_pend_word.sv
module cpi_pend_word #(
  parameter int PEND_W = 32,
  parameter int LVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PEND_W-1:0] set_mask,
  input  logic [PEND_W-1:0] clr_mask,
  input  logic              timer_in,
  input  logic              l15_in,
  input  logic [LVL_W-1:0]  hard_lvl,
  input  logic              is_target,
  output logic [PEND_W-1:0] pend_q,
  output logic [PEND_W-1:0] pend_d,
  output logic [PEND_W-1:0] view
);
  localparam int L15_BIT = LVL_W - 1;
  localparam int TMR_BIT = LVL_W - 2;

  logic [PEND_W-1:0] soft_q, soft_d;
  logic              tmr_q, l15_q, l15_d, l15_prev;
  logic              rise, fall;
  logic [PEND_W-1:0] hard_ext;

  assign rise = l15_in & ~l15_prev;
  assign fall = ~l15_in & l15_prev;

  always_comb begin
    soft_d          = (soft_q & ~clr_mask) | set_mask;
    soft_d[LVL_W:0] = '0;
  end

  always_comb begin
    if (rise)                   l15_d = 1'b1;
    else if (fall)              l15_d = 1'b0;
    else if (clr_mask[L15_BIT]) l15_d = 1'b0;
    else                        l15_d = l15_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q   <= '0;
      tmr_q    <= 1'b0;
      l15_q    <= 1'b0;
      l15_prev <= 1'b0;
    end else begin
      soft_q   <= soft_d;
      tmr_q    <= timer_in;
      l15_q    <= l15_d;
      l15_prev <= l15_in;
    end
  end

  always_comb begin
    pend_q          = soft_q;
    pend_q[TMR_BIT] = tmr_q;
    pend_q[L15_BIT] = l15_q;
    pend_d          = soft_d;
    pend_d[TMR_BIT] = timer_in;
    pend_d[L15_BIT] = l15_d;
  end

  always_comb begin
    hard_ext             = '0;
    hard_ext[LVL_W-1:1]  = is_target ? hard_lvl[LVL_W-1:1] : '0;
    view                 = pend_q | hard_ext;
  end
endmodule

// File: rtl/cpi_level_map.sv
module cpi_level_map #(
  parameter int PEND_W = 32,
  parameter int LVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PEND_W-1:0] pend_d,
  input  logic [LVL_W-1:0]  hard_lvl,
  input  logic              is_target,
  input  logic              master_off,
  output logic [LVL_W-1:0]  irl
);
  localparam int L15_BIT = LVL_W - 1;
  localparam int TMR_BIT = LVL_W - 2;

  logic [LVL_W-1:0] lv;

  always_comb begin
    lv = pend_d[LVL_W +: LVL_W];
    if (!master_off) begin
      lv[L15_BIT] = lv[L15_BIT] | pend_d[L15_BIT];
      lv[TMR_BIT] = lv[TMR_BIT] | pend_d[TMR_BIT];
      if (is_target) lv = lv | hard_lvl;
    end
    lv[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irl <= '0;
    else     irl <= lv;
  end
endmodule

// File: rtl/cpi_irq_pend.sv
module cpi_irq_pend #(
  parameter int ADDR_W = 2,
  parameter int PEND_W = 32,
  parameter int LVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PEND_W-1:0] wdata,
  output logic [PEND_W-1:0] rdata,
  input  logic              timer_in,
  input  logic              l15_in,
  input  logic [LVL_W-1:0]  hard_lvl,
  input  logic              is_target,
  input  logic              master_off,
  output logic [LVL_W-1:0]  irl
);
  logic [PEND_W-1:0] set_mask, clr_mask, pend_q, pend_d, view;

  cpi_regif #(.ADDR_W(ADDR_W), .PEND_W(PEND_W), .LVL_W(LVL_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .view(view), .set_mask(set_mask), .clr_mask(clr_mask),
    .rdata(rdata)
  );

  cpi_pend_word #(.PEND_W(PEND_W), .LVL_W(LVL_W)) u_pend (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .timer_in(timer_in), .l15_in(l15_in), .hard_lvl(hard_lvl),
    .is_target(is_target), .pend_q(pend_q), .pend_d(pend_d), .view(view)
  );

  cpi_level_map #(.PEND_W(PEND_W), .LVL_W(LVL_W)) u_map (
    .clk(clk), .rst(rst), .pend_d(pend_d), .hard_lvl(hard_lvl),
    .is_target(is_target), .master_off(master_off), .irl(irl)
  );
endmodule

// File: rtl/cpi_irq_pend_chk.sv
module cpi_irq_pend_chk #(
  parameter int ADDR_W = 2,
  parameter int PEND_W = 32,
  parameter int LVL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [PEND_W-1:0] wdata,
  input logic [PEND_W-1:0] rdata,
  input logic              timer_in,
  input logic              master_off,
  input logic [PEND_W-1:0] pend_q,
  input logic [LVL_W-1:0]  irl
);
  localparam int TMR_BIT = LVL_W - 2;

  p_lvl0_zero_r9: assert property (@(posedge clk) disable iff (rst)
    irl[0] == 1'b0);

  p_clear_top_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(1) && wdata[PEND_W-1]) |=> !pend_q[PEND_W-1]);

  p_set_top_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2) && wdata[PEND_W-1]) |=> pend_q[PEND_W-1]);

  p_timer_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q[TMR_BIT] == $past(timer_in));

  p_master_gate_r7: assert property (@(posedge clk) disable iff (rst)
    master_off |=> irl[LVL_W-1 -: 2] == pend_q[PEND_W-1 -: 2]);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (irl == '0 && pend_q == '0 && rdata == '0));
endmodule

bind cpi_irq_pend cpi_irq_pend_chk #(.ADDR_W(ADDR_W), .PEND_W(PEND_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .timer_in(timer_in), .master_off(master_off),
  .pend_q(pend_q), .irl(irl)
);

// File: tb/tb_cpi_irq_pend.sv
module tb_cpi_irq_pend;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 2;
  localparam int PEND_W = 32;
  localparam int LVL_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [PEND_W-1:0] wdata = '0;
  logic [PEND_W-1:0] rdata;
  logic              timer_in = 1'b0, l15_in = 1'b0;
  logic [LVL_W-1:0]  hard_lvl = '0;
  logic              is_target = 1'b0, master_off = 1'b0;
  logic [LVL_W-1:0]  irl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] m_soft;
  logic        m_tmr, m_l15, m_prev;
  logic [31:0] e_rd;
  logic [15:0] e_irl;

  cpi_irq_pend #(.ADDR_W(ADDR_W), .PEND_W(PEND_W), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .timer_in(timer_in), .l15_in(l15_in),
    .hard_lvl(hard_lvl), .is_target(is_target), .master_off(master_off),
    .irl(irl)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] f_view();
    logic [31:0] v;
    v = m_soft | (32'(m_tmr) << 14) | (32'(m_l15) << 15);
    if (is_target) v = v | {16'h0, hard_lvl & 16'hFFFE};
    return v;
  endfunction

  function automatic logic [15:0] f_irl();
    logic [15:0] v;
    v = m_soft[31:16];
    if (!master_off) begin
      v = v | ({m_l15, m_tmr} << 14);
      if (is_target) v = v | hard_lvl;
    end
    v[0] = 1'b0;
    return v;
  endfunction

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, advance the model, check after the edge
  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] smsk, cmsk;
    logic        rise, fall;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    e_rd = (r && a == 2'd0) ? f_view() : 32'h0;
    smsk = (w && a == 2'd2) ? (d & 32'hFFFE_0000) : 32'h0;
    cmsk = (w && a == 2'd1) ? (d & 32'hFFFE_8000) : 32'h0;
    m_soft = (m_soft & ~cmsk & 32'hFFFE_0000) | smsk;
    rise = l15_in & ~m_prev;
    fall = ~l15_in & m_prev;
    if (rise)         m_l15 = 1'b1;
    else if (fall)    m_l15 = 1'b0;
    else if (cmsk[15]) m_l15 = 1'b0;
    m_prev = l15_in;
    m_tmr  = timer_in;
    e_irl  = f_irl();
    @(negedge clk);
    chk32({16'h0, irl}, {16'h0, e_irl}, {tag, " irl"});
    chk32(rdata, e_rd, {tag, " rdata"});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_soft = '0; m_tmr = 1'b0; m_l15 = 1'b0; m_prev = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk32({16'h0, irl}, 32'h0, "R10 irl after reset");
    chk32(rdata, 32'h0, "R10 rdata after reset");
    rst = 1'b0;
    cyc(0, 1, 2'd0, 0, "R10 read after reset");

    // R3 / R6: set all soft bits
    cyc(1, 0, 2'd2, 32'hFFFF_FFFF, "R3 R6 set");
    chk32({16'h0, irl}, 32'h0000_FFFE, "R6 soft shift");
    cyc(0, 1, 2'd0, 0, "R1 read");
    chk32(rdata, 32'hFFFE_0000, "R1 R3 visible after set");
    // R2: clear one bit
    cyc(1, 0, 2'd1, 32'h0002_0000, "R2 clear bit17");
    chk32({16'h0, irl}, 32'h0000_FFFC, "R2 level1 dropped");
    cyc(1, 0, 2'd1, 32'hFFFF_FFFF, "R2 clear all");
    // R3: writes to offsets 3 and 0 ignored
    cyc(1, 0, 2'd3, 32'hFFFF_FFFF, "R3 offset3");
    cyc(1, 0, 2'd0, 32'hFFFF_FFFF, "R3 offset0");
    cyc(0, 1, 2'd0, 0, "R3 readback");
    chk32(rdata, 32'h0, "R3 ignored writes");
    // R4: timer
    timer_in = 1'b1;
    cyc(1, 0, 2'd1, 32'h0000_4000, "R4 timer");
    chk32({16'h0, irl}, 32'h0000_4000, "R4 timer level");
    // R7: master off masks timer
    master_off = 1'b1;
    cyc(0, 0, 2'd0, 0, "R7 master off");
    chk32({16'h0, irl}, 32'h0, "R7 timer masked");
    master_off = 1'b0; timer_in = 1'b0;
    // R5: rising edge wins over same-cycle clear
    l15_in = 1'b1;
    cyc(1, 0, 2'd1, 32'h0000_8000, "R5 edge vs clear");
    chk32({16'h0, irl}, 32'h0000_8000, "R5 edge wins");
    cyc(1, 0, 2'd1, 32'h0000_8000, "R5 sw clear");
    chk32({16'h0, irl}, 32'h0, "R5 cleared by sw");
    cyc(1, 0, 2'd2, 32'h0000_8000, "R3 cannot set bit15");
    l15_in = 1'b0;
    cyc(0, 0, 2'd0, 0, "R5 fall");
    // R8: hard vector
    hard_lvl = 16'h0F0F; is_target = 1'b1;
    cyc(0, 1, 2'd0, 0, "R8 hard in");
    chk32({16'h0, irl}, 32'h0000_0F0E, "R8 hard ORed");
    cyc(0, 1, 2'd1, 0, "R1 read offset1");
    chk32(rdata, 32'h0, "R1 offset1 zero");
    // R9: bit0 only
    hard_lvl = 16'h0001;
    cyc(0, 1, 2'd0, 0, "R9 level0");
    cyc(0, 1, 2'd0, 0, "R9 view bit0");
    chk32({16'h0, irl}, 32'h0, "R9 no level0");
    // R11: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      hard_lvl   = 16'($urandom);
      is_target  = ($urandom_range(0, 1) == 1);
      master_off = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 5) == 0) timer_in = ~timer_in;
      if ($urandom_range(0, 4) == 0) l15_in   = ~l15_in;
      cyc(($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1), a,
          $urandom, "R11 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule